// File: doc/BRIEF.md
# Supply Supervisor Reset Sequencer

This block turns a digital "supply below threshold" flag from an analog comparator into a clean system reset. It samples the flag on a free-running clock of known period. A below-threshold level must persist for a qualify window before it counts, so short negative-going dips are ignored. Once a low supply qualifies, reset is held asserted for as long as the supply stays low. After the supply recovers, reset stays asserted for a long hold window, and only then is released.

The qualify window and the hold window are parameters given in clock cycles. With a 1 MHz clock, the defaults give about 20 µs for the qualify window and about 240 ms for the hold window. The hold window must stay between 140 ms and 460 ms for the clock actually used. A second output shows when the hold timer is running. A polarity parameter makes the reset output either active-low or active-high.

The synchronous active-low input `rst_n` models the power-on state. While it is low, reset is asserted. When it is released, the full hold window is applied as soon as the supply reads good.

Top module: `supply_reset_seq`

## Requirements
- R1: While `rst_n` is low, reset is active and `hold_active` is 0.
- R2: After `rst_n` is released with the supply good, `hold_active` goes high after the next clock edge. It stays high for exactly HOLD_CYCLES clock cycles, with reset active throughout. Reset is released in the same cycle that `hold_active` falls.
- R3: From the released state, `supply_low` sampled high on QUAL_CYCLES consecutive edges qualifies a dip. Reset becomes active after edge QUAL_CYCLES+1, counted from the first high sample, and not earlier.
- R4: A run of fewer than QUAL_CYCLES high samples of `supply_low` never asserts reset. A single low sample between runs clears the count, so separate short runs do not add up.
- R5: While a qualified dip continues, reset stays active and `hold_active` stays 0.
- R6: After a qualified dip, the first edge that samples `supply_low` low leaves reset active and `hold_active` at 0. The second such edge raises `hold_active`, which then lasts HOLD_CYCLES cycles before reset is released.
- R7: A dip that qualifies while the hold timer is running drops `hold_active`, keeps reset active, and restarts the full HOLD_CYCLES window after the supply recovers.
- R8: A dip that does not qualify while the hold timer is running neither stops nor extends the hold. The hold still lasts exactly HOLD_CYCLES cycles.
- R9: With ACTIVE_LOW=1, `reset_out` is 0 while reset is active and 1 otherwise. With ACTIVE_LOW=0, the levels are inverted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running sampling clock of known period |
| rst_n | input | 1 | Synchronous active-low power-on state |
| supply_low | input | 1 | Comparator flag, 1 when the supply is below the trip threshold |
| reset_out | output | 1 | System reset, polarity set by ACTIVE_LOW |
| hold_active | output | 1 | 1 while the post-recovery hold timer is running |

## Verification
The bench builds two copies of the block, one with ACTIVE_LOW=1 and one with ACTIVE_LOW=0. Both use QUAL_CYCLES=4 and HOLD_CYCLES=20 and receive the same stimulus, so the polarity of every check is compared between the two. With these small windows, a sweep of dip lengths from one cycle up to well past the qualify window is cheap. The sweep lands exactly on the boundary between a dip that is ignored and one that causes a reset. The short hold window also allows every hold to be counted cycle by cycle, including holds interrupted by a qualified dip or crossed by an unqualified glitch.

// File: rtl/srs_pkg.sv
// Shared types for the supply reset sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package srs_pkg;

    // Sequencer phases: supply held low, hold timer running, reset released.
    typedef enum logic [1:0] {
        SEQ_LOW  = 2'd0,
        SEQ_HOLD = 2'd1,
        SEQ_RUN  = 2'd2
    } seq_state_t;

endpackage

// File: rtl/srs_dip_filter.sv
// Qualifier for the below-threshold flag. low_q goes high only after
// supply_low has been sampled high on QUAL_CYCLES consecutive edges.
// Any good sample clears the run count, so separate glitches never add up.
// Assumes: supply_low is already synchronous to clk.
module srs_dip_filter #(
    parameter int QUAL_CYCLES = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_low,
    output logic low_q
);

    localparam int CW = $clog2(QUAL_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(QUAL_CYCLES - 1);

    logic [CW-1:0] run_cnt;

    // Count consecutive low samples and flag the qualified condition.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_cnt <= '0;
            low_q   <= 1'b0;
        end else if (!supply_low) begin
            run_cnt <= '0;
            low_q   <= 1'b0;
        end else if (!low_q) begin
            if (run_cnt == LAST) begin
                low_q <= 1'b1;
            end else begin
                run_cnt <= run_cnt + 1'b1;
            end
        end
    end

    // R3: a qualified condition only appears after a low sample.
    p_qualify_from_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(low_q) |-> $past(supply_low));

    // R4: a good sample always clears the qualified condition.
    p_good_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_low |=> !low_q);

    // R4: the run count never passes the qualify limit.
    p_run_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        run_cnt <= LAST);

endmodule

// File: rtl/srs_hold_seq.sv
// Reset sequencer. Keeps reset active while the qualified low condition
// holds. After recovery it runs a hold timer of HOLD_CYCLES cycles, then
// releases reset. A qualified dip during the hold restarts the sequence.
// Assumes: low_q comes from srs_dip_filter, and supply_low is the raw flag.
module srs_hold_seq
    import srs_pkg::*;
#(
    parameter int HOLD_CYCLES = 240000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_low,
    input  logic low_q,
    output logic rst_act,
    output logic hold_active
);

    localparam int HW = $clog2(HOLD_CYCLES + 1);
    localparam logic [HW-1:0] HOLD_LAST = HW'(HOLD_CYCLES - 1);

    seq_state_t    state;
    logic [HW-1:0] hold_cnt;

    // Phase transitions and hold counting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= SEQ_LOW;
            hold_cnt <= '0;
        end else begin
            unique case (state)
                SEQ_LOW: begin
                    hold_cnt <= '0;
                    if (!low_q && !supply_low) begin
                        state <= SEQ_HOLD;
                    end
                end
                SEQ_HOLD: begin
                    if (low_q) begin
                        state    <= SEQ_LOW;
                        hold_cnt <= '0;
                    end else if (hold_cnt == HOLD_LAST) begin
                        state <= SEQ_RUN;
                    end else begin
                        hold_cnt <= hold_cnt + 1'b1;
                    end
                end
                SEQ_RUN: begin
                    hold_cnt <= '0;
                    if (low_q) begin
                        state <= SEQ_LOW;
                    end
                end
                default: begin
                    state    <= SEQ_LOW;
                    hold_cnt <= '0;
                end
            endcase
        end
    end

    // Decode the outputs from the phase.
    always_comb begin
        rst_act     = (state != SEQ_RUN);
        hold_active = (state == SEQ_HOLD);
    end

    // R2: the hold counter stays inside its window.
    p_hold_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        hold_cnt <= HOLD_LAST);

    // R7: a qualified dip during the hold aborts the hold.
    p_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_active && low_q) |=> !hold_active && rst_act);

    // R6: every hold starts from a zero count.
    p_hold_fresh_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hold_active) |-> hold_cnt == '0);

endmodule

// File: rtl/srs_out_drive.sv
// Output polarity stage. Maps the internal active-high reset request onto
// the selected output polarity.
// Assumes: rst_act comes from a registered phase decode.
module srs_out_drive #(
    parameter bit ACTIVE_LOW = 1'b1
) (
    input  logic rst_act,
    output logic reset_out
);

    generate
        if (ACTIVE_LOW) begin : g_low
            // Drive low while reset is requested.
            assign reset_out = ~rst_act;
        end else begin : g_high
            // Drive high while reset is requested.
            assign reset_out = rst_act;
        end
    endgenerate

endmodule

// File: rtl/supply_reset_seq.sv
// Supply supervisor reset sequencer top. Chain: dip qualifier, then the
// hold sequencer, then the polarity stage.
// Assumes: clk is free-running with a known period. QUAL_CYCLES and
// HOLD_CYCLES are set for that period (defaults match a 1 MHz clock).
module supply_reset_seq #(
    parameter int QUAL_CYCLES = 20,
    parameter int HOLD_CYCLES = 240000,
    parameter bit ACTIVE_LOW  = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_low,
    output logic reset_out,
    output logic hold_active
);

    logic low_q;
    logic rst_act;

    srs_dip_filter #(.QUAL_CYCLES(QUAL_CYCLES)) u_filter (
        .clk        (clk),
        .rst_n      (rst_n),
        .supply_low (supply_low),
        .low_q      (low_q)
    );

    srs_hold_seq #(.HOLD_CYCLES(HOLD_CYCLES)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .supply_low  (supply_low),
        .low_q       (low_q),
        .rst_act     (rst_act),
        .hold_active (hold_active)
    );

    srs_out_drive #(.ACTIVE_LOW(ACTIVE_LOW)) u_drive (
        .rst_act   (rst_act),
        .reset_out (reset_out)
    );

    // R5: a qualified low supply forces reset on the next edge.
    p_low_forces_reset_r5: assert property (@(posedge clk) disable iff (!rst_n)
        low_q |=> rst_act);

    // R2: reset is released only at the end of a hold.
    p_release_after_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rst_act) |-> $past(hold_active));

    // R1: the power-on state forces reset and stops the timer.
    p_por_reset_r1: assert property (@(posedge clk)
        !rst_n |=> rst_act && !hold_active);

endmodule

// File: tb/test_supply_reset_seq.sv
`timescale 1ns/1ps
module test_supply_reset_seq;

    localparam int Q = 4;
    localparam int H = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic supply_low = 1'b0;
    logic rout_lo, hold_lo, rout_hi, hold_hi;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    supply_reset_seq #(.QUAL_CYCLES(Q), .HOLD_CYCLES(H), .ACTIVE_LOW(1'b1)) i_supply_reset_seq (
        .clk(clk), .rst_n(rst_n), .supply_low(supply_low),
        .reset_out(rout_lo), .hold_active(hold_lo)
    );

    supply_reset_seq #(.QUAL_CYCLES(Q), .HOLD_CYCLES(H), .ACTIVE_LOW(1'b0)) i_supply_reset_seq_hi (
        .clk(clk), .rst_n(rst_n), .supply_low(supply_low),
        .reset_out(rout_hi), .hold_active(hold_hi)
    );

    task automatic chk(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic bit act_now();
        return !rout_lo;
    endfunction

    task automatic step();
        @(negedge clk);
    endtask

    // R9: both polarities and both hold flags agree.
    task automatic pol(string tag);
        chk(rout_lo == !rout_hi, {"R9 polarity ", tag}, int'(rout_hi), int'(!rout_lo));
        chk(hold_lo == hold_hi, {"R9 hold agree ", tag}, int'(hold_hi), int'(hold_lo));
    endtask

    task automatic wait_hold(int maxw, output int lat);
        lat = 0;
        while (!hold_lo && lat < maxw) begin
            step();
            lat++;
        end
    endtask

    // Counts the hold cycles that are observed high and checks reset during them.
    task automatic count_hold(output int n, output int bad);
        n = 0;
        bad = 0;
        while (hold_lo && n < H + 10) begin
            if (!act_now()) bad++;
            step();
            n++;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int lat, n, bad, first;
        step(); step(); step();
        // R1: power-on state
        chk(act_now() == 1'b1, "R1 reset active", int'(act_now()), 1);
        chk(hold_lo == 1'b0, "R1 hold idle", int'(hold_lo), 0);
        chk(rout_lo == 1'b0 && rout_hi == 1'b1, "R9 levels in reset", int'(rout_lo), 0);

        // R2: power-on hold
        rst_n = 1'b1;
        wait_hold(6, lat);
        chk(lat == 1, "R2 hold start latency", lat, 1);
        count_hold(n, bad);
        chk(n == H, "R2 hold length", n, H);
        chk(bad == 0, "R2 reset during hold", bad, 0);
        chk(act_now() == 1'b0, "R2 released", int'(act_now()), 0);
        chk(rout_lo == 1'b1 && rout_hi == 1'b0, "R9 levels released", int'(rout_lo), 1);

        // R3/R4/R6: sweep of dip lengths from the released state
        for (int len = 1; len <= Q + 3; len++) begin
            first = 0;
            supply_low = 1'b1;
            for (int i = 1; i <= len; i++) begin
                step();
                if (act_now() && first == 0) first = i;
            end
            supply_low = 1'b0;
            step();
            if (act_now() && first == 0) first = len + 1;
            pol($sformatf("sweep %0d", len));
            if (len >= Q) begin
                chk(first == Q + 1, $sformatf("R3 assert latency len=%0d", len), first, Q + 1);
                chk(hold_lo == 1'b0, "R6 no hold on first good edge", int'(hold_lo), 0);
                wait_hold(6, lat);
                chk(lat == 1, "R6 hold on second good edge", lat, 1);
                count_hold(n, bad);
                chk(n == H && bad == 0, $sformatf("R6 hold length len=%0d", len), n, H);
            end else begin
                chk(first == 0, $sformatf("R4 short dip len=%0d ignored", len), first, 0);
                step();
                chk(act_now() == 1'b0 && hold_lo == 1'b0, "R4 still released", int'(act_now()), 0);
            end
        end

        // R4: repeated sub-threshold runs separated by one good sample
        first = 0;
        for (int r = 0; r < 6; r++) begin
            supply_low = 1'b1;
            for (int i = 0; i < Q - 1; i++) begin
                step();
                if (act_now()) first++;
            end
            supply_low = 1'b0;
            step();
            if (act_now()) first++;
        end
        step();
        if (act_now()) first++;
        chk(first == 0, "R4 glitches do not accumulate", first, 0);

        // R5: long dip
        supply_low = 1'b1;
        bad = 0;
        for (int i = 1; i <= Q + 30; i++) begin
            step();
            if (i > Q && (!act_now() || hold_lo)) bad++;
        end
        chk(bad == 0, "R5 reset held during long dip", bad, 0);
        pol("long dip");
        supply_low = 1'b0;
        step();
        chk(act_now() && !hold_lo, "R6 first good edge keeps low phase", int'(hold_lo), 0);
        step();
        chk(hold_lo == 1'b1, "R6 second good edge starts hold", int'(hold_lo), 1);
        count_hold(n, bad);
        chk(n == H && bad == 0, "R6 hold after long dip", n, H);

        // R7: qualified dip during the hold
        supply_low = 1'b1;
        repeat (Q + 2) step();
        supply_low = 1'b0;
        wait_hold(6, lat);
        repeat (5) step();
        chk(hold_lo == 1'b1, "R7 hold running before dip", int'(hold_lo), 1);
        supply_low = 1'b1;
        repeat (Q) step();
        supply_low = 1'b0;
        step();
        chk(hold_lo == 1'b0 && act_now(), "R7 hold aborted", int'(hold_lo), 0);
        wait_hold(6, lat);
        chk(lat == 1, "R7 restart latency", lat, 1);
        count_hold(n, bad);
        chk(n == H && bad == 0, "R7 full hold after restart", n, H);

        // R8: unqualified glitch during the hold
        supply_low = 1'b1;
        repeat (Q + 2) step();
        supply_low = 1'b0;
        wait_hold(6, lat);
        n = 0;
        bad = 0;
        while (hold_lo && n < H + 10) begin
            if (!act_now()) bad++;
            supply_low = (n >= 3 && n < 3 + Q - 1);
            step();
            n++;
        end
        supply_low = 1'b0;
        chk(n == H, "R8 hold length with glitch", n, H);
        chk(bad == 0 && !act_now(), "R8 released after hold", int'(act_now()), 0);
        pol("end");

        // R1: power-on state again from the released phase
        rst_n = 1'b0;
        step();
        chk(act_now() && !hold_lo, "R1 reset re-entered", int'(act_now()), 1);

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule